// File: doc/BRIEF.md
# Dual-Mode Stochastic Stream Generator

This block turns fixed-point probability values into stochastic bit streams, one stream bit per lane on every clock. Each lane has its own encoding. In the concentrated encoding, the lane's value is compared with a period counter that all lanes share. All of the ones in each period therefore come first, as an unbroken run. In the Bernoulli encoding, the value is compared with the lane's own maximal-length LFSR, so the ones are spread pseudo-randomly across the period. The LFSRs all have the same structure and differ only in their seeds.

A start pulse sets the shared counter to zero and loads every LFSR from its seed. On the same clock it captures each lane's value and mode. That configuration then holds until the next start pulse. The counter runs freely with a period of 2^WIDTH cycles, so a stream can be consumed for any number of cycles. A period-done flag marks the last position of every period. A mixed assignment, with some lanes concentrated and some Bernoulli, lets a downstream stochastic circuit reduce its random error at no extra counter cost.

Top module: `ssg_stream_gen`

## Requirements
- R1: After reset, and until the first start pulse, every stream bit and period_done are 0.
- R2: A start pulse seen at a clock edge captures each lane's value and mode at that edge and loads each lane's LFSR from its seed. The cycle after the edge is position 0 of a new period.
- R3: A lane with mode bit 1 (concentrated) emits 1 at period position t exactly when t < value, for t = 0 .. 2^WIDTH-1. A value k therefore gives exactly k ones per period, all leading, and a value of 0 gives no ones.
- R4: A lane with mode bit 0 (Bernoulli) emits 1 exactly when its LFSR state is less than its value. At position 0 the LFSR state is the loaded seed. After that it advances every cycle as s' = {s[WIDTH-2:0], parity(s & TAP)}, with TAP = 8'hB8 for WIDTH 8.
- R5: A seed of 0 is loaded as the state 1.
- R6: period_done is 1 exactly in the cycle at position 2^WIDTH-1. The period repeats without a stop: position 0 follows, and the LFSRs keep advancing.
- R7: Changes on value_in, mode_in or seed_in without a start pulse have no effect on any stream.
- R8: A start pulse during a running period restarts it, even in the period's last cycle. In that cycle period_done is still 1, and the next cycle is position 0 with the new configuration and freshly loaded LFSRs.
- R9: Lanes are independent. Concentrated and Bernoulli lanes can be mixed freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse; captures the configuration and loads the seeds |
| value_in | input | LANES*WIDTH | Probability value per lane, lane i at bits [i*WIDTH +: WIDTH] |
| mode_in | input | LANES | Encoding per lane: 1 concentrated, 0 Bernoulli |
| seed_in | input | LANES*WIDTH | LFSR seed per lane, same packing as value_in |
| stream_out | output | LANES | One stream bit per lane |
| period_done | output | 1 | High in the last cycle of each period |

## Verification
A restart pulse and the end of a period can fall in the same cycle. The bench provokes this by driving start while the period position is all-ones. It then expects period_done to be high in that cycle and position 0 to follow, with the new values and modes and with the LFSRs reloaded from their seeds rather than advanced. The same cycle-by-cycle reference model also covers an uninterrupted wrap and a restart in the middle of a period. Those two cases show that the counter and the LFSRs take the reload in preference to the advance.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    // Feedback mask of a maximal-length Fibonacci LFSR for a given width
    function automatic logic [31:0] lfsr_taps(input int w);
        case (w)
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0E08;
            13:      return 32'h0000_1C80;
            14:      return 32'h0000_3802;
            15:      return 32'h0000_6000;
            16:      return 32'h0000_D008;
            default: return 32'h0000_00B8;
        endcase
    endfunction

endpackage

// File: rtl/ssg_period_counter.sv
module ssg_period_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [WIDTH-1:0] count,
    output logic             running,
    output logic             last
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             run;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = '0;
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign running = st_q.run;
    assign last    = st_q.run && (st_q.cnt == {WIDTH{1'b1}});

    // R2: a start pulse always opens at position 0
    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == '0) && running);
    // R6: after the last position comes position 0
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> (count == '0) && running);
    // R6: positions advance by one inside a period
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start && !last) |=> count == WIDTH'($past(count) + 1'b1));
endmodule

// File: rtl/ssg_lfsr.sv
module ssg_lfsr #(
    parameter int WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state
);
    localparam logic [WIDTH-1:0] SUBST = WIDTH'(1);

    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = (seed == '0) ? SUBST : seed;
        end else if (advance) begin
            sh_d = {sh_q[WIDTH-2:0], ^(sh_q & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign state = sh_q;

    // R5: a zero seed loads the substitute state
    a_r5_seed_subst: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == '0) |=> state == SUBST);
    // R5: an advancing register never sits in the lock-up state
    a_r5_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> state != '0);
endmodule

// File: rtl/ssg_lane.sv
module ssg_lane #(
    parameter int WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             running,
    input  logic             last,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] value_in,
    input  logic             mode_in,
    input  logic [WIDTH-1:0] seed_in,
    output logic             stream
);
    typedef struct packed {
        logic [WIDTH-1:0] level;
        logic             conc;
    } lane_cfg_t;

    lane_cfg_t        cfg_d, cfg_q;
    logic [WIDTH-1:0] rnd;
    logic [WIDTH-1:0] src;

    always_comb begin
        cfg_d = cfg_q;
        if (start) begin
            cfg_d.level = value_in;
            cfg_d.conc  = mode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    ssg_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .advance (running && !start),
        .seed    (seed_in),
        .state   (rnd)
    );

    assign src    = cfg_q.conc ? count : rnd;
    assign stream = running && (src < cfg_q.level);

    // R7: configuration only moves on a start pulse
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cfg_q));
    // R3: once a concentrated stream drops to 0 it stays 0 until the period ends
    a_r3_conc_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_q.conc && !start && !last && !stream) |=> !stream);
endmodule

// File: rtl/ssg_stream_gen.sv
module ssg_stream_gen #(
    parameter int LANES = 4,
    parameter int WIDTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LANES*WIDTH-1:0] value_in,
    input  logic [LANES-1:0]       mode_in,
    input  logic [LANES*WIDTH-1:0] seed_in,
    output logic [LANES-1:0]       stream_out,
    output logic                   period_done
);
    localparam logic [31:0]      TAPS_ALL = ssg_pkg::lfsr_taps(WIDTH);
    localparam logic [WIDTH-1:0] TAPS     = TAPS_ALL[WIDTH-1:0];

    logic [WIDTH-1:0] count;
    logic             running;
    logic             last;

    ssg_period_counter #(.WIDTH(WIDTH)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .count   (count),
        .running (running),
        .last    (last)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ssg_lane #(.WIDTH(WIDTH), .TAPS(TAPS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start),
            .running  (running),
            .last     (last),
            .count    (count),
            .value_in (value_in[i*WIDTH +: WIDTH]),
            .mode_in  (mode_in[i]),
            .seed_in  (seed_in[i*WIDTH +: WIDTH]),
            .stream   (stream_out[i])
        );
    end

    assign period_done = last;

    // R1: nothing is emitted before the first start pulse
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (stream_out == '0) && !period_done);
    // R6: the period flag is a single-cycle pulse unless a restart lands on it
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (period_done && !start) |=> !period_done);
endmodule

// File: tb/tb_ssg_stream_gen.sv
module tb_ssg_stream_gen;
    localparam int L = 4;
    localparam int W = 8;
    localparam int P = 256;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [L*W-1:0] value_in = '0;
    logic [L-1:0]   mode_in = '0;
    logic [L*W-1:0] seed_in = '0;
    logic [L-1:0]   stream_out;
    logic           period_done;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string phase = "R1";

    // reference model
    bit m_run = 1'b0;
    int m_pos = 0;
    int m_val[L];
    int m_conc[L];
    int m_rnd[L];

    always #10 clk = ~clk;

    ssg_stream_gen #(.LANES(L), .WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .value_in(value_in),
        .mode_in(mode_in), .seed_in(seed_in), .stream_out(stream_out),
        .period_done(period_done)
    );

    function automatic int next_rnd(input int s);
        int fb;
        fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
        return ((s << 1) | fb) & 255;
    endfunction

    task automatic set_lane(input int i, input int val, input bit conc, input int seed);
        value_in[i*W +: W] = W'(val);
        mode_in[i]         = conc;
        seed_in[i*W +: W]  = W'(seed);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s phase=%s pos=%0d actual=%0d expected=%0d", req, phase, m_pos, act, exp);
        end
    endtask

    task automatic compare_now();
        for (int i = 0; i < L; i++) begin
            int e;
            e = 0;
            if (m_run) e = ((m_conc[i] != 0) ? m_pos : m_rnd[i]) < m_val[i];
            check((m_conc[i] != 0) ? "R3 stream" : "R4 stream", int'(stream_out[i]), e);
        end
        check("R6 period_done", int'(period_done), int'(m_run && m_pos == P - 1));
    endtask

    task automatic tick();
        compare_now();
        @(posedge clk);
        if (start) begin
            for (int i = 0; i < L; i++) begin
                m_val[i]  = int'(value_in[i*W +: W]);
                m_conc[i] = int'(mode_in[i]);
                m_rnd[i]  = (seed_in[i*W +: W] == '0) ? 1 : int'(seed_in[i*W +: W]);
            end
            m_pos = 0;
            m_run = 1'b1;
        end else if (m_run) begin
            m_pos = (m_pos + 1) % P;
            for (int i = 0; i < L; i++) m_rnd[i] = next_rnd(m_rnd[i]);
        end
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < L; i++) begin
            m_val[i] = 0; m_conc[i] = 0; m_rnd[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle with busy inputs
        phase = "R1";
        set_lane(0, 200, 1'b1, 9);
        set_lane(2, 255, 1'b0, 77);
        for (int c = 0; c < 6; c++) tick();
        check("R1 idle streams", int'(stream_out), 0);

        // R2 R3 R4 R5 R9: mixed lanes, zero seed on lane 3
        phase = "R2 R9";
        set_lane(0, 3, 1'b1, 0);
        set_lane(1, 0, 1'b1, 0);
        set_lane(2, 128, 1'b0, 8'h5A);
        set_lane(3, 200, 1'b0, 0);
        pulse_start();
        check("R2 position 0 lane0 high", int'(stream_out[0]), 1);
        check("R5 zero seed gives state 1 (below 200)", int'(stream_out[3]), 1);
        begin
            int ones;
            ones = 0;
            phase = "R3 R7";
            for (int c = 0; c < P; c++) begin
                if (c == 40) begin
                    set_lane(0, 250, 1'b0, 3);
                    set_lane(1, 99, 1'b0, 5);
                end
                ones += int'(stream_out[0]);
                tick();
            end
            check("R3 ones per period lane0", ones, 3);
        end

        // R6: keep running across a second wrap
        phase = "R6";
        for (int c = 0; c < 20; c++) tick();

        // R8: restart mid-period with new modes
        phase = "R8 mid";
        set_lane(0, 255, 1'b1, 1);
        set_lane(1, 64, 1'b0, 8'hFF);
        set_lane(2, 1, 1'b1, 0);
        set_lane(3, 0, 1'b0, 8'h33);
        pulse_start();
        for (int c = 0; c < 300; c++) tick();

        // R8: restart exactly in the last cycle of a period
        phase = "R8 last";
        while (m_pos != P - 1) tick();
        check("R8 done high on restart cycle", int'(period_done), 1);
        set_lane(0, 2, 1'b0, 8'hC3);
        set_lane(1, 128, 1'b1, 0);
        set_lane(2, 0, 1'b0, 0);
        set_lane(3, 255, 1'b1, 0);
        pulse_start();
        check("R8 position 0 after restart", int'(period_done), 0);
        check("R8 lane1 concentrated at position 0", int'(stream_out[1]), 1);
        for (int c = 0; c < 270; c++) tick();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule